// File: doc/BRIEF.md
# I2C Serial Memory Slave

This block makes a byte-wide on-chip memory reachable as a slave on a two-wire I2C bus. It watches SCL and SDA with the system clock. It pulls SDA low through an open-drain style output when it acknowledges or sends a zero. Three select inputs give the low bits of its bus address, so up to eight copies can share one bus.

A master writes by sending the device byte with the direction bit clear. Two address bytes follow, then any number of data bytes. There is no page boundary and no internal write time, so a write burst can run for any length. The master reads by sending the device byte with the direction bit set. The slave returns bytes from its pointer for as long as the master acknowledges them. A write that carries only the two address bytes, followed by a repeated start, sets the pointer for a random-access read and stores nothing.

The internal pointer is 16 bits wide. The array is indexed by its low bits, so the pointer wraps at the array size.

Top module: `i2cmem_slave`

## Requirements
- R1: After reset the pointer is 0 and SDA is released. SDA also stays released whenever no transaction is open, meaning no start has been seen since the last stop or since reset.
- R2: The device byte is binary 1010, then devSel[2:0] (bit 2 first), then the direction bit (1 = read), most significant bit first. With devSel = 000, write is 0xA0 and read is 0xA1. The slave acknowledges only a matching byte. After a mismatch it acknowledges nothing and stores nothing until the next start.
- R3: For each byte the slave receives, it keeps SDA released during the eight data clocks. It pulls SDA low after the falling edge of the eighth SCL clock, so SDA is low before the ninth rising edge. It releases SDA after the ninth falling edge.
- R4: After a write-mode device byte, the first two bytes load the pointer, high byte first. Only the low log2(DEPTH) bits select the array location.
- R5: Every later byte of a write transaction is stored at the pointer and acknowledged, and the pointer then advances by one. There is no page limit, and the pointer goes from DEPTH-1 to 0.
- R6: A write transaction that sends only the two address bytes changes no stored byte, whether it ends with a stop or with a repeated start. A read that follows starts at the loaded address.
- R7: In read mode the slave sends the byte at the pointer, most significant bit first, changing SDA only while SCL is low. After each byte the pointer advances, wrapping from DEPTH-1 to 0. A master ACK (SDA low on the ninth clock) starts the next byte. A NAK ends output, and SDA stays released.
- R8: A read-mode device byte that follows a start with no address bytes returns data starting at the current pointer.
- R9: A stop inside a byte aborts the transaction. The partial byte is neither acknowledged nor stored, and the pointer keeps its value.
- R10: Start and stop are recognised as an SDA fall or rise while SCL is high, sampled on synchronised copies of both lines. The slave's own SDA output changes only while the synchronised SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the bus |
| rstN | input | 1 | Asynchronous active-low reset |
| sclIn | input | 1 | SCL level seen at the pin |
| sdaIn | input | 1 | SDA level seen at the pin (wired bus value) |
| devSel | input | 3 | Device select pins, the low address bits of the device byte |
| sdaPullLow | output | 1 | 1 pulls SDA low; 0 leaves it to the pull-up |

## Verification
The bench builds the slave with DEPTH = 64 and the default two synchroniser stages. At this depth a single 64-byte burst fills the whole array and brings the pointer back to zero. Wrap-around in both write and read bursts is reached within a few bytes. Ten of the sixteen pointer bits lie above the index, so address bytes with high bits set check that those bits fold away. The master holds each SCL phase for ten clocks, which leaves margin for the three-cycle sampling delay when the slave drives its acknowledge and data bits.

// File: rtl/i2cmem_pkg.sv
package i2cmem_pkg;

  // Fixed upper nibble of the device byte
  localparam logic [3:0] DEV_PREFIX = 4'b1010;

  // Strobes from the bus controller to the storage side
  typedef struct packed {
    logic shiftRx;   // take the sampled SDA level into the receive register
    logic latchHi;   // hold the received byte as the pointer high byte
    logic loadPtr;   // load pointer from high byte and received byte
    logic writeMem;  // store received byte at pointer, advance pointer
    logic loadTx;    // fetch byte at pointer for sending, advance pointer
    logic shiftTx;   // move to the next transmit bit
  } dpStrobe_t;

  typedef enum logic [2:0] {
    ST_IDLE,   // ignoring the bus until a start
    ST_RX,     // receiving eight bits
    ST_ACK,    // holding SDA low for the ninth clock
    ST_TX,     // sending eight bits
    ST_MACK    // waiting for the master acknowledge
  } busState_t;

  typedef enum logic [1:0] {
    ROLE_DEV,
    ROLE_AHI,
    ROLE_ALO,
    ROLE_DATA
  } byteRole_t;

endpackage

// File: rtl/i2cmem_linesync.sv
module i2cmem_linesync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclIn,
  input  logic sdaIn,
  output logic sclRise,
  output logic sclFall,
  output logic sdaLevel,
  output logic startSeen,
  output logic stopSeen
);
  localparam int CUR = STAGES - 1;
  localparam int PRV = STAGES;

  logic [STAGES:0] sclPipe;
  logic [STAGES:0] sdaPipe;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclPipe <= '1;
      sdaPipe <= '1;
    end else begin
      sclPipe <= {sclPipe[STAGES-1:0], sclIn};
      sdaPipe <= {sdaPipe[STAGES-1:0], sdaIn};
    end
  end

  assign sclRise   = sclPipe[CUR] & ~sclPipe[PRV];
  assign sclFall   = ~sclPipe[CUR] & sclPipe[PRV];
  assign sdaLevel  = sdaPipe[CUR];
  assign startSeen = sclPipe[CUR] & sclPipe[PRV] & sdaPipe[PRV] & ~sdaPipe[CUR];
  assign stopSeen  = sclPipe[CUR] & sclPipe[PRV] & ~sdaPipe[PRV] & sdaPipe[CUR];

endmodule

// File: rtl/i2cmem_ctrl.sv
module i2cmem_ctrl
  import i2cmem_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclRise,
  input  logic       sclFall,
  input  logic       sdaLevel,
  input  logic       startSeen,
  input  logic       stopSeen,
  input  logic [2:0] devSel,
  input  logic [7:0] rxByte,
  input  logic       txBit,
  output dpStrobe_t  strobe,
  output logic       sdaPullLow
);
  busState_t state, nextState;
  byteRole_t role, nextRole;
  logic [3:0] bitCnt, nextCnt;
  logic       readMode, nextRead;
  logic       masterAcked, nextMack;
  logic       devHit;

  assign devHit = (rxByte[7:1] == {DEV_PREFIX, devSel});

  always_comb begin
    strobe    = '0;
    nextState = state;
    nextRole  = role;
    nextCnt   = bitCnt;
    nextRead  = readMode;
    nextMack  = masterAcked;
    if (stopSeen) begin
      nextState = ST_IDLE;
    end else if (startSeen) begin
      nextState = ST_RX;
      nextRole  = ROLE_DEV;
      nextCnt   = 4'd0;
    end else begin
      case (state)
        ST_RX: begin
          if (sclRise) begin
            strobe.shiftRx = 1'b1;
            nextCnt        = bitCnt + 4'd1;
          end else if (sclFall && bitCnt == 4'd8) begin
            nextState = ST_ACK;
            case (role)
              ROLE_DEV: begin
                if (devHit) nextRead = rxByte[0];
                else        nextState = ST_IDLE;
              end
              ROLE_AHI: strobe.latchHi  = 1'b1;
              ROLE_ALO: strobe.loadPtr  = 1'b1;
              default:  strobe.writeMem = 1'b1;
            endcase
          end
        end
        ST_ACK: begin
          if (sclFall) begin
            nextCnt = 4'd0;
            if (role == ROLE_DEV && readMode) begin
              nextState     = ST_TX;
              strobe.loadTx = 1'b1;
            end else begin
              nextState = ST_RX;
              case (role)
                ROLE_DEV: nextRole = ROLE_AHI;
                ROLE_AHI: nextRole = ROLE_ALO;
                default:  nextRole = ROLE_DATA;
              endcase
            end
          end
        end
        ST_TX: begin
          if (sclFall) begin
            if (bitCnt == 4'd7) begin
              nextState = ST_MACK;
            end else begin
              strobe.shiftTx = 1'b1;
              nextCnt        = bitCnt + 4'd1;
            end
          end
        end
        ST_MACK: begin
          if (sclRise) begin
            nextMack = ~sdaLevel;
          end else if (sclFall) begin
            if (masterAcked) begin
              nextState     = ST_TX;
              strobe.loadTx = 1'b1;
              nextCnt       = 4'd0;
            end else begin
              nextState = ST_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state       <= ST_IDLE;
      role        <= ROLE_DEV;
      bitCnt      <= 4'd0;
      readMode    <= 1'b0;
      masterAcked <= 1'b0;
    end else begin
      state       <= nextState;
      role        <= nextRole;
      bitCnt      <= nextCnt;
      readMode    <= nextRead;
      masterAcked <= nextMack;
    end
  end

  assign sdaPullLow = (state == ST_ACK) | ((state == ST_TX) & ~txBit);

endmodule

// File: rtl/i2cmem_datapath.sv
module i2cmem_datapath
  import i2cmem_pkg::*;
#(
  parameter int DEPTH  = 256,
  parameter int ADDR_W = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  dpStrobe_t  strobe,
  input  logic       sdaLevel,
  output logic [7:0] rxByte,
  output logic       txBit
);
  localparam int IDX_W = $clog2(DEPTH);

  logic [7:0]        memArr [DEPTH];
  logic [7:0]        rxShift;
  logic [7:0]        txShift;
  logic [7:0]        hiByte;
  logic [ADDR_W-1:0] ptr;
  logic [IDX_W-1:0]  idx;

  // the array sees only the low pointer bits, so it wraps at DEPTH
  assign idx = ptr[IDX_W-1:0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxShift <= 8'h00;
      txShift <= 8'hFF;
      hiByte  <= 8'h00;
      ptr     <= '0;
    end else begin
      if (strobe.shiftRx) rxShift <= {rxShift[6:0], sdaLevel};
      if (strobe.latchHi) hiByte  <= rxShift;
      if (strobe.loadPtr) ptr     <= ADDR_W'({hiByte, rxShift});
      if (strobe.writeMem || strobe.loadTx) ptr <= ptr + ADDR_W'(1);
      if (strobe.loadTx)  txShift <= memArr[idx];
      else if (strobe.shiftTx) txShift <= {txShift[6:0], 1'b1};
    end
  end

  always_ff @(posedge clk) begin
    if (strobe.writeMem) memArr[idx] <= rxShift;
  end

  assign rxByte = rxShift;
  assign txBit  = txShift[7];

endmodule

// File: rtl/i2cmem_slave.sv
module i2cmem_slave
  import i2cmem_pkg::*;
#(
  parameter int DEPTH       = 256,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclIn,
  input  logic       sdaIn,
  input  logic [2:0] devSel,
  output logic       sdaPullLow
);
  localparam int ADDR_W = 16;

  logic       sclRise, sclFall, sdaLevel, startSeen, stopSeen;
  logic [7:0] rxByte;
  logic       txBit;
  dpStrobe_t  strobe;

  i2cmem_linesync #(.STAGES(SYNC_STAGES)) uSync (
    .clk      (clk),
    .rstN     (rstN),
    .sclIn    (sclIn),
    .sdaIn    (sdaIn),
    .sclRise  (sclRise),
    .sclFall  (sclFall),
    .sdaLevel (sdaLevel),
    .startSeen(startSeen),
    .stopSeen (stopSeen)
  );

  i2cmem_ctrl uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .sclRise   (sclRise),
    .sclFall   (sclFall),
    .sdaLevel  (sdaLevel),
    .startSeen (startSeen),
    .stopSeen  (stopSeen),
    .devSel    (devSel),
    .rxByte    (rxByte),
    .txBit     (txBit),
    .strobe    (strobe),
    .sdaPullLow(sdaPullLow)
  );

  i2cmem_datapath #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) uData (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .sdaLevel(sdaLevel),
    .rxByte  (rxByte),
    .txBit   (txBit)
  );

endmodule

// File: rtl/i2cmem_chk.sv
module i2cmem_chk #(
  parameter int SYNC_STAGES = 2
) (
  input logic       clk,
  input logic       rstN,
  input logic       sclIn,
  input logic       sdaIn,
  input logic [2:0] devSel,
  input logic       sdaPullLow
);
  logic [SYNC_STAGES:0] sclQ, sdaQ;
  logic       busOn;
  logic [3:0] riseCnt;
  logic [6:0] firstBits;
  logic sclNow, sclOld, sdaNow, sdaOld, startEv, stopEv;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclQ <= '1;
      sdaQ <= '1;
    end else begin
      sclQ <= {sclQ[SYNC_STAGES-1:0], sclIn};
      sdaQ <= {sdaQ[SYNC_STAGES-1:0], sdaIn};
    end
  end

  assign sclNow  = sclQ[SYNC_STAGES-1];
  assign sclOld  = sclQ[SYNC_STAGES];
  assign sdaNow  = sdaQ[SYNC_STAGES-1];
  assign sdaOld  = sdaQ[SYNC_STAGES];
  assign startEv = sclNow & sclOld & sdaOld & ~sdaNow;
  assign stopEv  = sclNow & sclOld & ~sdaOld & sdaNow;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busOn     <= 1'b0;
      riseCnt   <= 4'd0;
      firstBits <= 7'd0;
    end else if (startEv) begin
      busOn   <= 1'b1;
      riseCnt <= 4'd0;
    end else if (stopEv) begin
      busOn <= 1'b0;
    end else if (sclNow && !sclOld) begin
      if (riseCnt < 4'd7) firstBits <= {firstBits[5:0], sdaNow};
      if (riseCnt != 4'd15) riseCnt <= riseCnt + 4'd1;
    end
  end

  // R1
  idle_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busOn |-> !sdaPullLow);

  // R10
  sda_quiet_scl_high_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sdaPullLow) |-> !sclOld);

  // R3
  first_ack_slot_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(sdaPullLow) && riseCnt < 4'd9) |-> riseCnt == 4'd8);

  // R3
  first_ack_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(sdaPullLow) && riseCnt < 4'd10) |-> riseCnt == 4'd9);

  // R2
  dev_match_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(sdaPullLow) && riseCnt == 4'd8) |-> firstBits == {4'b1010, devSel});

endmodule

bind i2cmem_slave i2cmem_chk #(.SYNC_STAGES(SYNC_STAGES)) chkInst (
  .clk       (clk),
  .rstN      (rstN),
  .sclIn     (sclIn),
  .sdaIn     (sdaIn),
  .devSel    (devSel),
  .sdaPullLow(sdaPullLow)
);

// File: tb/tb_i2cmem_slave.sv
`timescale 1ns/1ps
module tb_i2cmem_slave;
  localparam int DEPTH = 64;
  localparam int Q     = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       sclLine = 1'b1;
  logic       mPull = 1'b0;
  logic [2:0] devSel = 3'b000;
  logic       sdaPullLow;
  logic       sdaBus;

  assign sdaBus = ~(mPull | sdaPullLow);

  always #2.5 clk = ~clk;

  i2cmem_slave #(.DEPTH(DEPTH)) dut (
    .clk       (clk),
    .rstN      (rstN),
    .sclIn     (sclLine),
    .sdaIn     (sdaBus),
    .devSel    (devSel),
    .sdaPullLow(sdaPullLow)
  );

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;
  bit sdaWobble = 1'b0;

  logic [7:0] refMem [DEPTH];
  int         refPtr = 0;
  logic [7:0] wrBuf [64];
  logic [7:0] rdBuf [64];

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] expAt(input int a);
    return refMem[a % DEPTH];
  endfunction

  function automatic void refWrite(input int a, input int n);
    for (int i = 0; i < n; i++) refMem[(a + i) % DEPTH] = wrBuf[i];
    refPtr = (a + n) % DEPTH;
  endfunction

  task automatic waitQ(input int n);
    repeat (n * Q) @(negedge clk);
  endtask

  task automatic busStart();
    mPull = 1'b0; waitQ(1);
    sclLine = 1'b1; waitQ(1);
    mPull = 1'b1; waitQ(1);
    sclLine = 1'b0; waitQ(1);
  endtask

  task automatic busStop();
    mPull = 1'b1; waitQ(1);
    sclLine = 1'b1; waitQ(1);
    mPull = 1'b0; waitQ(1);
  endtask

  task automatic sendBits(input logic [7:0] b, input int cnt, output bit pulled);
    pulled = 1'b0;
    for (int i = 7; i > 7 - cnt; i--) begin
      mPull = ~b[i]; waitQ(1);
      sclLine = 1'b1; waitQ(2);
      if (sdaPullLow) pulled = 1'b1;
      sclLine = 1'b0; waitQ(1);
    end
  endtask

  task automatic sendByte(input logic [7:0] b, output bit acked,
                          output bit pullEarly, output bit pullLate);
    sendBits(b, 8, pullEarly);
    mPull = 1'b0; waitQ(1);
    sclLine = 1'b1; waitQ(1);
    acked = ~sdaBus;
    waitQ(1);
    sclLine = 1'b0; waitQ(1);
    pullLate = sdaPullLow;
  endtask

  task automatic recvByte(input bit giveAck, output logic [7:0] b);
    logic first;
    mPull = 1'b0;
    for (int i = 7; i >= 0; i--) begin
      waitQ(1);
      sclLine = 1'b1;
      first = sdaBus;
      waitQ(1);
      b[i] = sdaBus;
      if (first !== sdaBus) sdaWobble = 1'b1;
      waitQ(1);
      sclLine = 1'b0;
      waitQ(1);
    end
    mPull = giveAck; waitQ(1);
    sclLine = 1'b1; waitQ(2);
    sclLine = 1'b0; waitQ(1);
    mPull = 1'b0;
  endtask

  task automatic writeTxn(input logic [2:0] sel, input logic [15:0] addr, input int n,
                          output bit ackAll, output bit timingOk);
    bit a, e, l;
    ackAll = 1'b1; timingOk = 1'b1;
    busStart();
    sendByte({4'b1010, sel, 1'b0}, a, e, l); ackAll &= a; timingOk &= ~e & ~l;
    sendByte(addr[15:8], a, e, l);           ackAll &= a; timingOk &= ~e & ~l;
    sendByte(addr[7:0], a, e, l);            ackAll &= a; timingOk &= ~e & ~l;
    for (int i = 0; i < n; i++) begin
      sendByte(wrBuf[i], a, e, l); ackAll &= a; timingOk &= ~e & ~l;
    end
    busStop();
  endtask

  task automatic readRandom(input logic [2:0] sel, input logic [15:0] addr, input int n,
                            output bit ackAll);
    bit a, e, l;
    ackAll = 1'b1;
    busStart();
    sendByte({4'b1010, sel, 1'b0}, a, e, l); ackAll &= a;
    sendByte(addr[15:8], a, e, l);           ackAll &= a;
    sendByte(addr[7:0], a, e, l);            ackAll &= a;
    busStart();
    sendByte({4'b1010, sel, 1'b1}, a, e, l); ackAll &= a;
    for (int i = 0; i < n; i++) recvByte(i != n - 1, rdBuf[i]);
    busStop();
  endtask

  task automatic readCurrent(input logic [2:0] sel, input int n, output bit ackAll);
    bit a, e, l;
    busStart();
    sendByte({4'b1010, sel, 1'b1}, a, e, l); ackAll = a;
    for (int i = 0; i < n; i++) recvByte(i != n - 1, rdBuf[i]);
    busStop();
  endtask

  task automatic compareRead(input int a, input int n, input string req);
    for (int i = 0; i < n; i++)
      check(rdBuf[i] === expAt(a + i), req, $sformatf("read byte %0d at %0d", i, (a + i) % DEPTH),
            rdBuf[i], expAt(a + i));
  endtask

  initial begin : watchdog
    repeat (195000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin : main
    bit ok, tOk, pulled, a, e, l;
    int addr, n;
    void'($urandom(32'd2024));

    repeat (4) @(negedge clk);
    check(sdaPullLow == 1'b0, "R1", "SDA released in reset", sdaPullLow, 0);
    rstN = 1'b1;
    repeat (4) @(negedge clk);
    check(sdaPullLow == 1'b0, "R1", "SDA released after reset", sdaPullLow, 0);

    // R5: fill the whole array in one burst, no page limit
    for (int i = 0; i < DEPTH; i++) wrBuf[i] = 8'((i * 7 + 3) ^ 8'h5A);
    writeTxn(3'b000, 16'h0000, DEPTH, ok, tOk);
    refWrite(0, DEPTH);
    check(ok, "R5", "full burst acknowledged", ok, 1);
    check(tOk, "R3", "ack only after eighth fall, released after ninth", tOk, 1);

    // R7: read the whole array back
    readRandom(3'b000, 16'h0000, DEPTH, ok);
    refPtr = 0;
    check(ok, "R7", "read setup acknowledged", ok, 1);
    compareRead(0, DEPTH, "R7");
    check(sdaPullLow == 1'b0, "R7", "SDA released after NAK", sdaPullLow, 0);
    check(!sdaWobble, "R10", "SDA stable while SCL high in read", sdaWobble, 0);

    // R4, R5: write wrap with high address bits that fold away
    wrBuf[0] = 8'hC1; wrBuf[1] = 8'hC2; wrBuf[2] = 8'hC3; wrBuf[3] = 8'hC4;
    writeTxn(3'b000, 16'h12FE, 4, ok, tOk);
    refWrite(16'h12FE % DEPTH, 4);
    check(ok && tOk, "R5", "wrapping write acknowledged", ok, 1);
    readRandom(3'b000, 16'd62, 2, ok);
    compareRead(62, 2, "R4");
    readRandom(3'b000, 16'd0, 2, ok);
    compareRead(0, 2, "R5");

    // R7: read burst wrapping across the top
    readRandom(3'b000, 16'd63, 3, ok);
    refPtr = (63 + 3) % DEPTH;
    compareRead(63, 3, "R7");

    // R8: current-address read continues from the pointer
    readCurrent(3'b000, 2, ok);
    check(ok, "R8", "current read acknowledged", ok, 1);
    compareRead(refPtr, 2, "R8");
    refPtr = (refPtr + 2) % DEPTH;

    // R6: address-only write ended by stop, then current read
    writeTxn(3'b000, 16'd20, 0, ok, tOk);
    refPtr = 20;
    readCurrent(3'b000, 1, ok);
    compareRead(20, 1, "R6");
    refPtr = 21;

    // R2: mismatched select and prefix
    devSel = 3'b101;
    wrBuf[0] = 8'h00;
    writeTxn(3'b000, 16'd30, 1, ok, tOk);
    check(!ok, "R2", "wrong select not acknowledged", ok, 0);
    busStart();
    sendByte(8'hBA, a, e, l);
    check(!a, "R2", "wrong prefix not acknowledged", a, 0);
    sendByte(8'h00, a, e, l);
    sendByte(8'd31, a, e, l);
    sendByte(8'h00, a, e, l);
    check(!a && !e, "R2", "bus ignored after mismatch", a, 0);
    busStop();
    readRandom(3'b101, 16'd30, 2, ok);
    check(ok, "R2", "matching select acknowledged", ok, 1);
    compareRead(30, 2, "R2");
    refPtr = 32;

    // R9: stop inside a data byte
    busStart();
    sendByte(8'hAA, a, e, l);
    sendByte(8'h00, a, e, l);
    sendByte(8'd10, a, e, l);
    sendBits(8'h00, 4, pulled);
    busStop();
    check(!pulled && !sdaPullLow, "R9", "no ack for aborted byte", pulled, 0);
    readCurrent(3'b101, 1, ok);
    compareRead(10, 1, "R9");
    devSel = 3'b000;

    // R1: reset returns pointer to zero
    readRandom(3'b000, 16'd5, 1, ok);
    @(negedge clk); rstN = 1'b0;
    repeat (3) @(negedge clk); rstN = 1'b1;
    repeat (3) @(negedge clk);
    readCurrent(3'b000, 1, ok);
    compareRead(0, 1, "R1");

    // R6, R7: random bursts written and read back by random access
    for (int it = 0; it < 6; it++) begin
      addr = int'($urandom_range(16'hFFFF, 0));
      n = int'($urandom_range(4, 1));
      for (int i = 0; i < n; i++) wrBuf[i] = 8'($urandom);
      writeTxn(3'b000, 16'(addr), n, ok, tOk);
      refWrite(addr % DEPTH, n);
      check(ok && tOk, "R5", "random burst acknowledged", ok, 1);
      readRandom(3'b000, 16'(addr), n, ok);
      compareRead(addr % DEPTH, n, "R6");
    end
    check(!sdaWobble, "R10", "SDA stable while SCL high overall", sdaWobble, 0);

    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule